// File: doc/BRIEF.md
# H-Bridge Direction Sequencer

This block turns a single direction request into the four switch-close lines of an H-bridge motor driver. The bridge has two legs. Switches 1 and 3 share the left leg and switches 2 and 4 share the right leg. Closing the diagonal 1/4 turns the motor clockwise and closing the diagonal 2/3 turns it counterclockwise. With all four open the motor is off. If both switches of one leg are closed, the supply is shorted, so that pattern must never appear at the outputs.

The direction request is asynchronous to the block's clock and passes through a two-stage synchronizer. Every change of the synchronized direction makes the block open all four switches. The switches then stay open for a programmable dead interval of `GAP_CYCLES` clocks before the matching diagonal closes. The default of 800,000 cycles gives a 100 ms gap at an 8 MHz clock. After reset the block also waits one full dead interval before it closes any pair. If the request flips back during the interval, the interval restarts and aims at the latest direction. A `busy` output is high while the switches are held open.

The controller has three states. `HB_GAP` holds all switches open and runs the gap timer. `HB_CW` drives the 1/4 diagonal and `HB_CCW` drives the 2/3 diagonal. The transitions are:

- GAP_RESTART goes from HB_GAP to HB_GAP. The synchronized direction differs from the current target, so the target is updated and the timer is cleared.
- GAP_DONE goes from HB_GAP to HB_CW or to HB_CCW. The timer has reached its last count and the direction still equals the target.
- REVERSE goes from HB_CW or HB_CCW to HB_GAP. The synchronized direction no longer matches the driven pair.
- HOLD keeps the current drive state. The synchronized direction still matches.

Top module: `hbridge_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters HB_GAP. After that edge all four switch outputs are 0 and `busy` is 1.
- R2: After reset is released, the first switch pair closes on exactly the `GAP_CYCLES`-th clock edge, provided the direction is unchanged. Until then all switches stay open.
- R3: In HB_CW the outputs are sw1=1, sw2=0, sw3=0, sw4=1. This state is entered only when the synchronized direction is 1.
- R4: In HB_CCW the outputs are sw1=0, sw2=1, sw3=1, sw4=0. This state is entered only when the synchronized direction is 0.
- R5: A direction change while a pair is driven opens all switches on the third clock edge after the change at `dir_req`. One diagonal never follows the other directly in consecutive cycles.
- R6: Once the switches open, they stay open for at least `GAP_CYCLES` clock cycles. The new pair closes on the `GAP_CYCLES`-th edge after the opening edge when the direction is stable.
- R7: A direction change seen during the dead interval restarts the interval from zero. The pair that closes afterwards is the one for the latest direction.
- R8: Neither leg pair (sw1 with sw3, sw2 with sw4) is ever closed at the same time.
- R9: `busy` is 1 exactly when the block is in HB_GAP. Whenever `busy` is 1, all four switch outputs are 0.
- R10: `dir_req` reaches the controller through two flip-flops. A change at `dir_req` has no effect on the outputs for the first two clock edges after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_req | input | 1 | Requested direction: 1 clockwise, 0 counterclockwise; asynchronous |
| sw1 | output | 1 | Close left-high switch (1 = closed) |
| sw2 | output | 1 | Close right-high switch |
| sw3 | output | 1 | Close left-low switch |
| sw4 | output | 1 | Close right-low switch |
| busy | output | 1 | High while all switches are forced open |

## Verification
The hardest situation to reach from the ports is a reversal that arrives inside a running dead interval. It must land late enough that an interval which did not restart would already have closed a pair. The stimulus reverses a steady clockwise drive and waits five cycles. It then flips the request back and checks that the switches are still open on the edge where the first interval would have ended. It also checks that the clockwise pair closes a full interval after the restart. A long phase of random toggling then puts reversals at every timer count, including the last one, where restart and completion compete.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        HB_GAP = 2'd0,
        HB_CW  = 2'd1,
        HB_CCW = 2'd2
    } hb_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic s4;
    } hb_sw_t;

    localparam hb_sw_t SW_OPEN = '{s1: 1'b0, s2: 1'b0, s3: 1'b0, s4: 1'b0};
    localparam hb_sw_t SW_CW   = '{s1: 1'b1, s2: 1'b0, s3: 1'b0, s4: 1'b1};
    localparam hb_sw_t SW_CCW  = '{s1: 1'b0, s2: 1'b1, s3: 1'b1, s4: 1'b0};

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
    parameter int GAP_CYCLES = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CNT_W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (en && !done)   cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/hb_leg_guard.sv
module hb_leg_guard
    import hb_pkg::*;
(
    input  hb_sw_t raw,
    output hb_sw_t safe
);
    logic [1:0] leg_short;

    assign leg_short[0] = raw.s1 & raw.s3;
    assign leg_short[1] = raw.s2 & raw.s4;

    always_comb begin
        if (|leg_short) safe = SW_OPEN;
        else            safe = raw;
    end
endmodule

// File: rtl/hbridge_seq.sv
module hbridge_seq
    import hb_pkg::*;
#(
    parameter int GAP_CYCLES  = 800000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_req,
    output logic sw1,
    output logic sw2,
    output logic sw3,
    output logic sw4,
    output logic busy
);
    hb_state_e state_q, state_d;
    logic      tgt_q, tgt_d;
    logic      dir_sync;
    logic      tmr_clr, tmr_done;
    hb_sw_t    sw_raw, sw_safe;

    hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dir_req),
        .q     (dir_sync)
    );

    hb_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (state_q == HB_GAP),
        .done  (tmr_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        tmr_clr = 1'b0;
        unique case (state_q)
            HB_GAP: begin
                if (dir_sync != tgt_q) begin          // GAP_RESTART
                    tgt_d   = dir_sync;
                    tmr_clr = 1'b1;
                end else if (tmr_done) begin          // GAP_DONE
                    state_d = tgt_q ? HB_CW : HB_CCW;
                end
            end
            HB_CW: begin
                if (!dir_sync) begin                  // REVERSE
                    state_d = HB_GAP;
                    tgt_d   = 1'b0;
                    tmr_clr = 1'b1;
                end
            end
            HB_CCW: begin
                if (dir_sync) begin                   // REVERSE
                    state_d = HB_GAP;
                    tgt_d   = 1'b1;
                    tmr_clr = 1'b1;
                end
            end
            default: begin
                state_d = HB_GAP;
                tmr_clr = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HB_GAP;
            tgt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            HB_CW:   sw_raw = SW_CW;
            HB_CCW:  sw_raw = SW_CCW;
            default: sw_raw = SW_OPEN;
        endcase
    end

    hb_leg_guard u_guard (
        .raw  (sw_raw),
        .safe (sw_safe)
    );

    assign sw1  = sw_safe.s1;
    assign sw2  = sw_safe.s2;
    assign sw3  = sw_safe.s3;
    assign sw4  = sw_safe.s4;
    assign busy = (state_q == HB_GAP);
endmodule

// File: rtl/hbridge_seq_chk.sv
module hbridge_seq_chk #(
    parameter int GAP_CYCLES = 800000
) (
    input logic clk,
    input logic rst_n,
    input logic sw1,
    input logic sw2,
    input logic sw3,
    input logic sw4,
    input logic busy,
    input logic dir_sync
);
    logic [31:0] open_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                    open_run <= '0;
        else if (!busy)                open_run <= '0;
        else if (open_run != '1)       open_run <= open_run + 1'b1;
    end

    assert_reset_open_R1: assert property (@(posedge clk)
        !rst_n |=> (busy && !sw1 && !sw2 && !sw3 && !sw4));

    assert_cw_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw1 && sw4) |-> $past(dir_sync));

    assert_ccw_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw2 && sw3) |-> !$past(dir_sync));

    assert_break_before_make_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw1 && sw4) |=> !(sw2 || sw3)) and ((sw2 && sw3) |=> !(sw1 || sw4)));

    assert_gap_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (open_run >= 32'(GAP_CYCLES)));

    assert_no_leg_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw1 && sw3) && !(sw2 && sw4));

    assert_busy_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones({sw1, sw2, sw3, sw4}) == 0));
endmodule

bind hbridge_seq hbridge_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw1      (sw1),
    .sw2      (sw2),
    .sw3      (sw3),
    .sw4      (sw4),
    .busy     (busy),
    .dir_sync (dir_sync)
);

// File: tb/hbridge_seq_tb.sv
module hbridge_seq_tb;
    localparam int GAP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_req = 1'b0;
    logic sw1, sw2, sw3, sw4, busy;

    int checks = 0;
    int fails  = 0;

    // reference model: mode 0 open, 1 clockwise, 2 counterclockwise
    int m_mode = 0;
    int m_tgt  = 0;
    int m_el   = 0;
    int m_q[$] = '{0, 0};

    always #4 clk = ~clk;

    hbridge_seq #(.GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_req(dir_req),
        .sw1(sw1), .sw2(sw2), .sw3(sw3), .sw4(sw4), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int seen;
        if (!rst_n) begin
            m_mode = 0; m_tgt = 0; m_el = 0;
            m_q = '{0, 0};
        end else begin
            seen = m_q[0];
            void'(m_q.pop_front());
            m_q.push_back(int'(dir_req));
            if (m_mode == 0) begin
                if (seen != m_tgt) begin
                    m_tgt = seen; m_el = 0;
                end else if (m_el >= GAP - 1) begin
                    m_mode = (m_tgt == 1) ? 1 : 2;
                end else begin
                    m_el++;
                end
            end else if (seen != ((m_mode == 1) ? 1 : 0)) begin
                m_mode = 0; m_tgt = seen; m_el = 0;
            end
        end
    end

    // compare with the model on every clock
    always @(negedge clk) begin
        int act, exp;
        string tag;
        act = {28'd0, sw1, sw2, sw3, sw4};
        exp = (m_mode == 1) ? 4'b1001 : (m_mode == 2) ? 4'b0110 : 4'b0000;
        tag = (!rst_n) ? "R1" : (m_mode == 1) ? "R3" : (m_mode == 2) ? "R4" : "R6";
        check(act == exp, tag, "switch pattern", act, exp);
        check(int'(busy) == int'(m_mode == 0), "R9", "busy", int'(busy), int'(m_mode == 0));
        check(!((sw1 && sw3) || (sw2 && sw4)), "R8", "leg short", act, 0);
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cyc(2);
        check(busy && !sw1 && !sw2 && !sw3 && !sw4, "R1", "reset state",
              {27'd0, busy, sw1, sw2, sw3, sw4}, 16);
        rst_n = 1'b1;
        cyc(GAP - 1);
        check(busy == 1'b1, "R2", "still open before gap end", int'(busy), 1);
        cyc(1);
        check(sw2 && sw3 && !busy, "R2", "first pair after gap", {29'd0, sw2, sw3, busy}, 6);
        cyc(4);

        // reversal to clockwise
        dir_req = 1'b1;
        cyc(2);
        check(sw2 == 1'b1, "R10", "no effect within two edges", int'(sw2), 1);
        cyc(1);
        check(busy && !sw2 && !sw3, "R5", "open on third edge", int'(busy), 1);
        cyc(GAP - 1);
        check(busy == 1'b1, "R6", "open through gap", int'(busy), 1);
        cyc(1);
        check(sw1 && sw4 && !busy, "R6", "clockwise after gap", {29'd0, sw1, sw4, busy}, 6);
        cyc(4);

        // flip back during the dead interval
        dir_req = 1'b0;
        cyc(5);
        dir_req = 1'b1;
        cyc(6);
        check(busy == 1'b1, "R7", "interval restarted", int'(busy), 1);
        cyc(4);
        check(busy == 1'b1, "R7", "open until restart ends", int'(busy), 1);
        cyc(1);
        check(sw1 && sw4, "R7", "latest direction driven", {30'd0, sw1, sw4}, 3);
        cyc(3);

        // random toggling
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 11) == 0) dir_req = ~dir_req;
            cyc(1);
        end

        // reset in the middle of driving
        rst_n = 1'b0;
        cyc(1);
        check(busy && !sw1 && !sw2 && !sw3 && !sw4, "R1", "reset mid run",
              {27'd0, busy, sw1, sw2, sw3, sw4}, 16);
        rst_n = 1'b1;
        cyc(GAP + 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule